// File: doc/BRIEF.md
# Paged Receive Ring Buffer Manager

This block places incoming frames into a circular receive area in local packet memory. The memory is split into 256-byte pages. The ring covers the contiguous pages from a configured first page up to, but not including, a configured limit page. The host owns a boundary page, which marks the oldest page it has not yet consumed. The block owns a current page, which marks where the next frame will be placed. The host can also load the current page directly while it sets the block up.

When a frame starts, its bytes are written one per cycle, beginning at offset 4 of the current page. This leaves a 4-byte header slot in front of the data. When the frame ends with a good indication, the header is filled in with four single-byte writes, and the current page then moves to the page that follows the frame's last byte. A frame may be rejected, may arrive while monitor mode is on, or may run out of ring space. In each of these cases the current page stays where it was, so any partial data is abandoned. Running out of space and monitor mode both count the frame as missed. Running out of space also raises a sticky overwrite flag and a reset-status indication.

Top module: `ring_rx_mgr`

## Requirements
- R1: After reset, curPage is 0, memWe is 0, and ovwFlag, rstStat and missedPulse are all 0.
- R2: After frmStart, each byte accepted with frmValid is written exactly once, in order. The first byte goes to offset 4 of the current page. Each following byte goes to the next address.
- R3: When the byte after offset 255 of a page would fall on the limit page cfgStop, writing continues at offset 0 of page cfgStart.
- R4: For a good frame (frmEnd with frmOk=1), the header is written to offsets 0..3 of the current page, in this order:
  - offset 0: the frmStatus byte;
  - offset 1: the next-frame page number;
  - offset 2: the low byte of the count;
  - offset 3: the high byte of the count.
  The count is the frame's data length plus 4.
- R5: The next-frame page is the ring page that follows the page holding the frame's last header or data byte. curPage takes this value only after all four header bytes have been written.
- R6: A frame that ends with frmOk=0 gets no header write, and curPage keeps its value.
- R7: If a data byte would land at offset 0 of the boundary page:
  - that byte and all later bytes of the frame are not written;
  - missedPulse is high for one cycle;
  - ovwFlag and rstStat are set;
  - curPage keeps its value.
- R8: A frame that starts while monitorEn is 1 causes no memory write, pulses missedPulse once, and leaves curPage unchanged.
- R9: ovwFlag stays set until ovwClr is pulsed, and ovwClr does not clear rstStat. rstStat clears when the host changes the bndry value.
- R10: A curSet pulse loads curSetVal into curPage on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgStart | input | 8 | First page of the ring |
| cfgStop | input | 8 | Limit page; one past the last ring page |
| bndry | input | 8 | Host-owned boundary page |
| monitorEn | input | 1 | Check frames without storing them |
| curSet | input | 1 | Load strobe for the current page |
| curSetVal | input | 8 | Value loaded by curSet |
| ovwClr | input | 1 | Clears the overwrite flag |
| frmStart | input | 1 | Frame begins (accepted when idle) |
| frmValid | input | 1 | frmData holds a frame byte |
| frmData | input | 8 | Frame byte |
| frmEnd | input | 1 | Frame ends |
| frmOk | input | 1 | Frame is good, qualified by frmEnd |
| frmStatus | input | 8 | Status byte for the header, qualified by frmEnd |
| curPage | output | 8 | Current page register |
| ovwFlag | output | 1 | Sticky overwrite flag |
| rstStat | output | 1 | Reset-status indication |
| missedPulse | output | 1 | One-cycle missed-frame pulse |
| memWe | output | 1 | Packet memory write enable |
| memAddr | output | 16 | Packet memory byte address {page, offset} |
| memWdata | output | 8 | Packet memory write data |

## Verification
Short frames that stay inside one page check where the data starts and what goes in the header. A frame whose last byte lands exactly at offset 255 checks that the next-frame page is computed right at a page edge. A frame that starts on the last ring page must fold back to the first page; this shows whether the wrap works and whether the next page is counted after the wrap. A long frame with the boundary two pages ahead, a rejected frame and a monitored frame each check that nothing is committed. Together they also show whether the missed, overwrite and reset-status indications come from the right cause. Random lengths and boundary distances then mix these cases; the bench works out the expected placement and header independently from the same page arithmetic.

// File: rtl/ring_rx_pkg.sv
package ring_rx_pkg;
  localparam int HDR_LEN = 4;
  localparam int CNT_W   = 16;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FILL,
    ST_HDR,
    ST_DROP
  } rxState_t;

  typedef struct packed {
    logic       beginFrame;
    logic       storeByte;
    logic       sealFrame;
    logic       hdrWe;
    logic [1:0] hdrIdx;
    logic       commit;
  } rxStrobe_t;
endpackage

// File: rtl/ring_rx_ctrl.sv
module ring_rx_ctrl
  import ring_rx_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      frmStart,
  input  logic      frmValid,
  input  logic      frmEnd,
  input  logic      frmOk,
  input  logic      monitorEn,
  input  logic      ovwClr,
  input  logic      crossFull,
  input  logic      bndryMoved,
  output rxStrobe_t strb,
  output logic      ovwFlag,
  output logic      rstStat,
  output logic      missedPulse
);
  rxState_t   state, stateNext;
  logic [1:0] idxReg;
  logic       missSet;
  logic       overflow;

  always_comb begin
    strb      = '0;
    stateNext = state;
    missSet   = 1'b0;
    overflow  = 1'b0;
    case (state)
      ST_IDLE: begin
        if (frmStart) begin
          if (monitorEn) begin
            missSet   = 1'b1;
            stateNext = ST_DROP;
          end else begin
            strb.beginFrame = 1'b1;
            stateNext       = ST_FILL;
          end
        end
      end
      ST_FILL: begin
        if (frmEnd) begin
          if (frmOk) begin
            strb.sealFrame = 1'b1;
            stateNext      = ST_HDR;
          end else begin
            stateNext = ST_IDLE;
          end
        end else if (frmValid) begin
          if (crossFull) begin
            overflow  = 1'b1;
            stateNext = ST_DROP;
          end else begin
            strb.storeByte = 1'b1;
          end
        end
      end
      ST_HDR: begin
        strb.hdrWe  = 1'b1;
        strb.hdrIdx = idxReg;
        if (idxReg == 2'd3) begin
          strb.commit = 1'b1;
          stateNext   = ST_IDLE;
        end
      end
      default: begin
        if (frmEnd) stateNext = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      idxReg      <= 2'd0;
      ovwFlag     <= 1'b0;
      rstStat     <= 1'b0;
      missedPulse <= 1'b0;
    end else begin
      state       <= stateNext;
      idxReg      <= (state == ST_HDR) ? idxReg + 2'd1 : 2'd0;
      missedPulse <= missSet | overflow;
      if (overflow)    ovwFlag <= 1'b1;
      else if (ovwClr) ovwFlag <= 1'b0;
      if (overflow)        rstStat <= 1'b1;
      else if (bndryMoved) rstStat <= 1'b0;
    end
  end

  // R7: running into the boundary flags the frame as missed and overwritten
  assert_ovw_on_overflow_R7: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_FILL && !frmEnd && frmValid && crossFull) |=> (ovwFlag && rstStat && missedPulse));

  // R8: a monitored frame goes straight to dropping and is counted as missed
  assert_monitor_drop_R8: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && frmStart && monitorEn) |=> (state == ST_DROP && missedPulse));

  // R9: reset status only falls after the host moved the boundary
  assert_rst_clear_R9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rstStat) |-> $past(bndryMoved));

  // R9: the overwrite flag only falls on a clear request
  assert_ovw_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ovwFlag) |-> $past(ovwClr));
endmodule

// File: rtl/ring_rx_dpath.sv
module ring_rx_dpath
  import ring_rx_pkg::*;
#(
  parameter int PG_W  = 8,
  parameter int OFF_W = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  rxStrobe_t              strb,
  input  logic [PG_W-1:0]        cfgStart,
  input  logic [PG_W-1:0]        cfgStop,
  input  logic [PG_W-1:0]        bndry,
  input  logic                   curSet,
  input  logic [PG_W-1:0]        curSetVal,
  input  logic [7:0]             frmData,
  input  logic [7:0]             frmStatus,
  output logic                   crossFull,
  output logic                   bndryMoved,
  output logic [PG_W-1:0]        curPage,
  output logic                   memWe,
  output logic [PG_W+OFF_W-1:0]  memAddr,
  output logic [7:0]             memWdata
);
  localparam int ADDR_W = PG_W + OFF_W;

  logic [PG_W-1:0]  wrPage, wrPageNext, sealNext, bndryPrev;
  logic [OFF_W-1:0] wrOff;
  logic [CNT_W-1:0] byteCnt, sealCnt;
  logic [7:0]       sealStatus;
  logic [7:0]       hdrByte;

  function automatic logic [PG_W-1:0] ringNext(input logic [PG_W-1:0] p);
    logic [PG_W-1:0] inc;
    inc = p + PG_W'(1);
    return (inc == cfgStop) ? cfgStart : inc;
  endfunction

  assign wrPageNext = ringNext(wrPage);
  assign crossFull  = (wrOff == '0) && (wrPage == bndry);
  assign bndryMoved = (bndry != bndryPrev);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPage     <= '0;
      wrOff      <= '0;
      byteCnt    <= '0;
      sealStatus <= '0;
      sealNext   <= '0;
      sealCnt    <= '0;
      curPage    <= '0;
      bndryPrev  <= '0;
    end else begin
      bndryPrev <= bndry;
      if (strb.beginFrame) begin
        wrPage  <= curPage;
        wrOff   <= OFF_W'(HDR_LEN);
        byteCnt <= '0;
      end else if (strb.storeByte) begin
        wrOff   <= wrOff + OFF_W'(1);
        byteCnt <= byteCnt + CNT_W'(1);
        if (&wrOff) wrPage <= wrPageNext;
      end
      if (strb.sealFrame) begin
        sealStatus <= frmStatus;
        sealNext   <= (wrOff == '0) ? wrPage : wrPageNext;
        sealCnt    <= byteCnt + CNT_W'(HDR_LEN);
      end
      if (curSet)           curPage <= curSetVal;
      else if (strb.commit) curPage <= sealNext;
    end
  end

  always_comb begin
    case (strb.hdrIdx)
      2'd0:    hdrByte = sealStatus;
      2'd1:    hdrByte = 8'(sealNext);
      2'd2:    hdrByte = sealCnt[7:0];
      default: hdrByte = sealCnt[CNT_W-1:8];
    endcase
  end

  assign memWe    = strb.storeByte | strb.hdrWe;
  assign memAddr  = strb.hdrWe ? {curPage, {(OFF_W-2){1'b0}}, strb.hdrIdx}
                               : {wrPage, wrOff};
  assign memWdata = strb.hdrWe ? hdrByte : frmData;

  // R6: current page only moves on a commit or a host load
  assert_cur_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.commit && !curSet) |=> $stable(curPage));

  // R7: no data byte ever opens the boundary page
  assert_no_bndry_entry_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.storeByte && memAddr[OFF_W-1:0] == '0) |-> (memAddr[ADDR_W-1:OFF_W] != bndry));

  // R3: with a sane ring and current page, writes stay inside the ring
  assert_in_ring_R3: assert property (@(posedge clk) disable iff (!rstN)
    (memWe && cfgStart < cfgStop && curPage >= cfgStart && curPage < cfgStop &&
     wrPage >= cfgStart && wrPage < cfgStop)
    |-> (memAddr[ADDR_W-1:OFF_W] >= cfgStart && memAddr[ADDR_W-1:OFF_W] < cfgStop));

  // R4: header bytes land in the first four bytes of the current page
  assert_hdr_slot_R4: assert property (@(posedge clk) disable iff (!rstN)
    strb.hdrWe |-> (memAddr[ADDR_W-1:OFF_W] == curPage && memAddr[OFF_W-1:2] == '0));
endmodule

// File: rtl/ring_rx_mgr.sv
module ring_rx_mgr
  import ring_rx_pkg::*;
#(
  parameter int PG_W  = 8,
  parameter int OFF_W = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [PG_W-1:0]       cfgStart,
  input  logic [PG_W-1:0]       cfgStop,
  input  logic [PG_W-1:0]       bndry,
  input  logic                  monitorEn,
  input  logic                  curSet,
  input  logic [PG_W-1:0]       curSetVal,
  input  logic                  ovwClr,
  input  logic                  frmStart,
  input  logic                  frmValid,
  input  logic [7:0]            frmData,
  input  logic                  frmEnd,
  input  logic                  frmOk,
  input  logic [7:0]            frmStatus,
  output logic [PG_W-1:0]       curPage,
  output logic                  ovwFlag,
  output logic                  rstStat,
  output logic                  missedPulse,
  output logic                  memWe,
  output logic [PG_W+OFF_W-1:0] memAddr,
  output logic [7:0]            memWdata
);
  rxStrobe_t strb;
  logic      crossFull;
  logic      bndryMoved;

  ring_rx_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .frmStart   (frmStart),
    .frmValid   (frmValid),
    .frmEnd     (frmEnd),
    .frmOk      (frmOk),
    .monitorEn  (monitorEn),
    .ovwClr     (ovwClr),
    .crossFull  (crossFull),
    .bndryMoved (bndryMoved),
    .strb       (strb),
    .ovwFlag    (ovwFlag),
    .rstStat    (rstStat),
    .missedPulse(missedPulse)
  );

  ring_rx_dpath #(.PG_W(PG_W), .OFF_W(OFF_W)) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .cfgStart  (cfgStart),
    .cfgStop   (cfgStop),
    .bndry     (bndry),
    .curSet    (curSet),
    .curSetVal (curSetVal),
    .frmData   (frmData),
    .frmStatus (frmStatus),
    .crossFull (crossFull),
    .bndryMoved(bndryMoved),
    .curPage   (curPage),
    .memWe     (memWe),
    .memAddr   (memAddr),
    .memWdata  (memWdata)
  );
endmodule

// File: tb/ring_rx_mgr_test.sv
`timescale 1ns/1ps
module ring_rx_mgr_test;
  localparam logic [7:0] START = 8'h40;
  localparam logic [7:0] STOP  = 8'h48;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] cfgStart = START, cfgStop = STOP, bndry = 8'h00, curSetVal = 8'h00;
  logic monitorEn = 1'b0, curSet = 1'b0, ovwClr = 1'b0;
  logic frmStart = 1'b0, frmValid = 1'b0, frmEnd = 1'b0, frmOk = 1'b0;
  logic [7:0] frmData = 8'h00, frmStatus = 8'h00;
  logic [7:0] curPage;
  logic ovwFlag, rstStat, missedPulse, memWe;
  logic [15:0] memAddr;
  logic [7:0] memWdata;

  int testN = 0, failN = 0, wrN = 0, missN = 0;
  logic [7:0] cap [int];
  logic [7:0] dat [0:2047];
  logic [7:0] curModel;

  always #2.5 clk = ~clk;

  ring_rx_mgr uut (
    .clk(clk), .rstN(rstN), .cfgStart(cfgStart), .cfgStop(cfgStop), .bndry(bndry),
    .monitorEn(monitorEn), .curSet(curSet), .curSetVal(curSetVal), .ovwClr(ovwClr),
    .frmStart(frmStart), .frmValid(frmValid), .frmData(frmData), .frmEnd(frmEnd),
    .frmOk(frmOk), .frmStatus(frmStatus), .curPage(curPage), .ovwFlag(ovwFlag),
    .rstStat(rstStat), .missedPulse(missedPulse), .memWe(memWe), .memAddr(memAddr),
    .memWdata(memWdata)
  );

  always @(posedge clk) begin
    if (memWe) begin
      cap[int'(memAddr)] = memWdata;
      wrN++;
    end
    if (missedPulse) missN++;
  end

  initial begin
    repeat (150000) @(posedge clk);
    testN++; failN++;
    $display("FAIL watchdog: run hung, actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", testN, failN);
    $finish;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    testN++;
    if (!ok) begin
      failN++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] nx(input logic [7:0] p);
    return (p + 8'd1 == STOP) ? START : p + 8'd1;
  endfunction

  function automatic logic [15:0] addrOf(input logic [7:0] cp, input int k);
    logic [7:0] pg = cp;
    for (int j = 0; j < k / 256; j++) pg = nx(pg);
    return {pg, 8'(k % 256)};
  endfunction

  task automatic loadCur(input logic [7:0] v);
    @(negedge clk); curSet = 1'b1; curSetVal = v;
    @(negedge clk); curSet = 1'b0;
    curModel = v;
  endtask

  // Drives one frame and checks it against the page-arithmetic model.
  task automatic doFrame(input int len, input bit ok, input logic [7:0] st,
                         input logic [7:0] bnd, input string req);
    int ovf = -1;
    int nWr, missBefore, bad;
    logic [7:0] expNext;
    logic [15:0] a;
    bit stored;
    for (int i = 0; i < len; i++) begin
      int k = 4 + i;
      a = addrOf(curModel, k);
      if (ovf < 0 && (k % 256) == 0 && a[15:8] == bnd) ovf = i;
      dat[i] = 8'($urandom);
    end
    expNext = nx(addrOf(curModel, 3 + len) >> 8);
    stored = !monitorEn && ok && ovf < 0;
    @(negedge clk);
    bndry = bnd;
    cap.delete(); wrN = 0; missBefore = missN;
    frmStart = 1'b1;
    @(negedge clk); frmStart = 1'b0;
    for (int i = 0; i < len; i++) begin
      frmValid = 1'b1; frmData = dat[i];
      @(negedge clk);
    end
    frmValid = 1'b0; frmEnd = 1'b1; frmOk = ok; frmStatus = st;
    @(negedge clk); frmEnd = 1'b0; frmOk = 1'b0;
    repeat (8) @(negedge clk);

    if (monitorEn) nWr = 0;
    else if (ovf >= 0) nWr = ovf;
    else nWr = ok ? len + 4 : len;
    chk(wrN == nWr, req, "write count", wrN, nWr);
    bad = 0;
    for (int i = 0; i < nWr && i < len; i++) begin
      a = addrOf(curModel, 4 + i);
      if (!cap.exists(int'(a)) || cap[int'(a)] != dat[i]) bad++;
    end
    chk(bad == 0, req, "data placement errors", bad, 0);
    if (stored) begin
      a = {curModel, 8'h00};
      chk(cap.exists(int'(a)) && cap[int'(a)] == st, "R4", "hdr status",
          cap.exists(int'(a)) ? int'(cap[int'(a)]) : -1, st);
      chk(cap.exists(int'(a+1)) && cap[int'(a+1)] == expNext, "R5", "hdr next page",
          cap.exists(int'(a+1)) ? int'(cap[int'(a+1)]) : -1, expNext);
      chk(cap.exists(int'(a+2)) && cap.exists(int'(a+3)) &&
          {cap[int'(a+3)], cap[int'(a+2)]} == 16'(len + 4), "R4", "hdr count",
          (cap.exists(int'(a+2)) && cap.exists(int'(a+3))) ?
            int'({cap[int'(a+3)], cap[int'(a+2)]}) : -1, len + 4);
      chk(curPage == expNext, "R5", "current page advance", curPage, expNext);
      curModel = expNext;
    end else begin
      chk(!cap.exists(int'({curModel, 8'h00})), req, "no header", 1, 0);
      chk(curPage == curModel, req, "current page held", curPage, curModel);
    end
    chk(missN - missBefore == ((monitorEn || ovf >= 0) ? 1 : 0), req, "missed pulses",
        missN - missBefore, (monitorEn || ovf >= 0) ? 1 : 0);
    if (ovf >= 0 && !monitorEn) begin
      chk(ovwFlag == 1'b1, "R7", "overwrite flag", ovwFlag, 1);
      chk(rstStat == 1'b1, "R7", "reset status", rstStat, 1);
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    curModel = 8'h00;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(curPage == 8'h00 && memWe == 1'b0, "R1", "reset cur/we", {curPage, 7'd0, memWe}, 0);
    chk(!ovwFlag && !rstStat && !missedPulse, "R1", "reset flags",
        {ovwFlag, rstStat, missedPulse}, 0);
    rstN = 1'b1;
    @(negedge clk);
    // R10: host load of the current page
    loadCur(START);
    chk(curPage == START, "R10", "current page load", curPage, START);

    // R2 R4 R5: short good frame inside one page
    doFrame(60, 1'b1, 8'h21, 8'h47, "R2");
    // R5: last byte lands on offset 255
    doFrame(252, 1'b1, 8'h01, 8'h47, "R5");
    // R3: frame starting on the last ring page wraps to the first
    loadCur(8'h47);
    doFrame(300, 1'b1, 8'h05, 8'h45, "R3");
    chk(curModel == 8'h41, "R3", "wrapped next page", curModel, 8'h41);
    // R6: rejected frame
    doFrame(100, 1'b0, 8'h02, 8'h45, "R6");
    // R7: overflow with boundary two pages ahead
    doFrame(700, 1'b1, 8'h01, nx(nx(curModel)), "R7");
    // R9: clear request resets only the overwrite flag
    @(negedge clk); ovwClr = 1'b1;
    @(negedge clk); ovwClr = 1'b0;
    chk(ovwFlag == 1'b0 && rstStat == 1'b1, "R9", "ovwClr effect", {ovwFlag, rstStat}, 1);
    @(negedge clk); bndry = bndry + 8'd1;
    repeat (2) @(negedge clk);
    chk(rstStat == 1'b0, "R9", "reset status cleared by boundary move", rstStat, 0);
    // R8: monitor mode
    monitorEn = 1'b1;
    doFrame(40, 1'b1, 8'h01, 8'h40, "R8");
    monitorEn = 1'b0;

    // random mix
    for (int n = 0; n < 30; n++) begin
      logic [7:0] b = curModel;
      int hop = $urandom_range(1, 7);
      for (int j = 0; j < hop; j++) b = nx(b);
      doFrame($urandom_range(0, 900), ($urandom_range(0, 4) != 0), 8'($urandom), b, "R2");
      if (ovwFlag) begin
        @(negedge clk); ovwClr = 1'b1;
        @(negedge clk); ovwClr = 1'b0;
      end
    end

    $display("  [TB] %0d tests run, %0d failed", testN, failN);
    $finish;
  end
endmodule